// File: doc/BRIEF.md
# Dual Bidirectional GPIO Port

This block provides two 8-bit general-purpose I/O ports for a small controller. Each port holds an output value register and a direction register, and bit n of each register controls pin n of that port. A single-cycle register bus writes either register and reads back the data register of either port. A read flag marks bit-manipulation (read-modify-write) accesses. Such reads return the output register contents rather than the pin level, so a bit that an external driver pulls against its output value is not lost when software writes the register back.

Pin levels pass through a two-stage synchronizer before they reach the read path. While the device is in stop mode, the pin inputs are gated to 0 ahead of the synchronizer. A pin-float control bit, together with stop mode, turns every output driver off. When an external-bus mode flag is raised, the ports release their pins and ignore the bus.

Register map: address 0 is port 0 data, address 1 is port 0 direction, address 2 is port 1 data, address 3 is port 1 direction. Address bit 0 selects direction (1) or data (0), and the upper address bit selects the port.

Top module: `gpio_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both output registers and both direction registers clear to 0, so `pin_oe` and `pin_out` are all 0 after that edge.
- R2: A write (`bus_wr`=1) to address 0 or 2 loads `bus_wdata` into that port's output register at the clock edge. Bit n of port p then appears on `pin_out[p*8+n]`, and the other port is unchanged.
- R3: A write to address 1 or 3 loads that port's direction register. When neither float condition nor external-bus mode is active, `pin_oe[p*8+n]` equals direction bit n (1 = drive, 0 = input).
- R4: A read of address 0 or 2 with `bus_rmw`=0 returns the port's pin levels, sampled through two clock edges. A change on `pin_in` is visible on `bus_rdata` after the second rising edge and not after the first.
- R5: A read of address 0 or 2 with `bus_rmw`=1 returns that port's output register contents, whatever the pins show.
- R6: A read of address 1 or 3 always returns 0.
- R7: While `stop_mode`=1 and `pin_float`=1, every `pin_oe` bit is 0 whatever the direction registers hold. Stop mode with `pin_float`=0 leaves `pin_oe` unchanged.
- R8: While `stop_mode`=1, the pin inputs are gated to 0 ahead of the synchronizer, so a normal data read returns 0 two edges later. Read-modify-write reads still return the output register.
- R9: While `ext_bus_mode`=1, bus writes change neither register, every `pin_oe` bit is 0, and `bus_rdata` is 0. Clearing the flag restores the earlier pin drive.
- R10: A read-modify-write sequence keeps an output bit at 1 even when an external driver holds that pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (bit 0: 0 data, 1 direction; bit 1: port) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rmw | input | 1 | Marks the current read as read-modify-write |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| stop_mode | input | 1 | Device is in stop mode |
| pin_float | input | 1 | In stop mode, float all pins when 1 |
| ext_bus_mode | input | 1 | Pins are handed to the external bus; registers inert |
| pin_in | input | 16 | Pin levels, port p bit n at index p*8+n |
| pin_oe | output | 16 | Output driver enable per pin |
| pin_out | output | 16 | Output value per pin |

## Verification
A corrupted output register shows on `pin_out` on the edge after the write and on every later read-modify-write read. A corrupted direction bit shows on `pin_oe` in the same cycle. A synchronizer that is too short or too long is exposed because the bench reads the port after exactly one and after exactly two edges. A read path that selects the pin instead of the register under the read-modify-write flag shows as a lost latch bit once the value is written back while the pin is held low.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    localparam int NUM_PORTS   = 2;
    localparam int PORT_BITS   = 8;
    localparam int SYNC_DEPTH  = 2;
    localparam int ADDR_BITS   = $clog2(NUM_PORTS) + 1;
    localparam int PIN_TOTAL   = NUM_PORTS * PORT_BITS;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_BITS-2:0] port;
        reg_sel_e             sel;
    } reg_addr_t;

    function automatic reg_addr_t split_addr(input logic [ADDR_BITS-1:0] a);
        reg_addr_t r;
        r.port = a[ADDR_BITS-1:1];
        r.sel  = reg_sel_e'(a[0]);
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = gpio_pair_pkg::PORT_BITS,
    parameter int STAGES = gpio_pair_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
    parameter int W      = gpio_pair_pkg::PORT_BITS,
    parameter int STAGES = gpio_pair_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_data,
    input  logic         we_dir,
    input  logic [W-1:0] wdata,
    input  logic         rmw,
    input  logic         float_req,
    input  logic         hand_off,
    input  logic         stop,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_gated;
    logic [W-1:0] pin_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (we_data) latch_q <= wdata;
            if (we_dir)  dir_q   <= wdata;
        end
    end

    // stop mode blocks the input path before sampling
    assign pin_gated = stop ? '0 : pin_in;

    gpio_in_sync #(.W(W), .STAGES(STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_gated),
        .q   (pin_sync)
    );

    assign oe     = (float_req || hand_off) ? '0 : dir_q;
    assign out    = latch_q;
    assign rd_val = rmw ? latch_q : pin_sync;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (latch_q == '0) && (dir_q == '0));

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        we_data |=> latch_q == $past(wdata));

    // R9
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hand_off |=> $stable(latch_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pair_pkg::*;
#(
    parameter int NP = NUM_PORTS,
    parameter int W  = PORT_BITS,
    parameter int AW = ADDR_BITS
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            hand_off,
    input  logic [NP*W-1:0] bank_rd,
    output logic [NP-1:0]   we_data,
    output logic [NP-1:0]   we_dir,
    output logic [W-1:0]    rdata
);
    localparam int PIW = AW - 1;

    reg_addr_t ra;
    assign ra = split_addr(addr);

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_we
            assign we_data[p] = wr && !hand_off && (ra.port == PIW'(p)) && (ra.sel == REG_DATA);
            assign we_dir[p]  = wr && !hand_off && (ra.port == PIW'(p)) && (ra.sel == REG_DIR);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (!hand_off && ra.sel == REG_DATA) begin
            for (int i = 0; i < NP; i++) begin
                if (ra.port == PIW'(i)) rdata = bank_rd[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/gpio_pair.sv
module gpio_pair
    import gpio_pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic [PORT_BITS-1:0] bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rmw,
    output logic [PORT_BITS-1:0] bus_rdata,
    input  logic                 stop_mode,
    input  logic                 pin_float,
    input  logic                 ext_bus_mode,
    input  logic [PIN_TOTAL-1:0] pin_in,
    output logic [PIN_TOTAL-1:0] pin_oe,
    output logic [PIN_TOTAL-1:0] pin_out
);
    logic                 float_req;
    logic [NUM_PORTS-1:0] we_data;
    logic [NUM_PORTS-1:0] we_dir;
    logic [PIN_TOTAL-1:0] bank_rd;

    assign float_req = stop_mode && pin_float;

    gpio_bus_decode #(.NP(NUM_PORTS), .W(PORT_BITS), .AW(ADDR_BITS)) dec_i (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .hand_off (ext_bus_mode),
        .bank_rd  (bank_rd),
        .we_data  (we_data),
        .we_dir   (we_dir),
        .rdata    (bus_rdata)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            gpio_port_bank #(.W(PORT_BITS), .STAGES(SYNC_DEPTH)) bank_i (
                .clk       (clk),
                .rst       (rst),
                .we_data   (we_data[p]),
                .we_dir    (we_dir[p]),
                .wdata     (bus_wdata),
                .rmw       (bus_rmw),
                .float_req (float_req),
                .hand_off  (ext_bus_mode),
                .stop      (stop_mode),
                .pin_in    (pin_in[p*PORT_BITS +: PORT_BITS]),
                .oe        (pin_oe[p*PORT_BITS +: PORT_BITS]),
                .out       (pin_out[p*PORT_BITS +: PORT_BITS]),
                .rd_val    (bank_rd[p*PORT_BITS +: PORT_BITS])
            );
        end
    endgenerate

    // R7
    stop_float_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && pin_float) |-> pin_oe == '0);

    // R6
    dir_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr[0] |-> bus_rdata == '0);
endmodule

// File: tb/gpio_pair_tb_top.sv
module gpio_pair_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rmw;
    logic [7:0]  bus_rdata;
    logic        stop_mode;
    logic        pin_float;
    logic        ext_bus_mode;
    logic [15:0] pin_in;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_lat [2];
    logic [7:0] exp_dir [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pair dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
        .stop_mode(stop_mode), .pin_float(pin_float), .ext_bus_mode(ext_bus_mode),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic rmw, output logic [7:0] d);
        bus_addr = a; bus_rmw = rmw;
        #1;
        d = bus_rdata;
    endtask

    task automatic two_edges();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] prev;
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rmw = 1'b0;
        stop_mode = 1'b0; pin_float = 1'b0; ext_bus_mode = 1'b0; pin_in = '0;
        exp_lat[0] = '0; exp_lat[1] = '0; exp_dir[0] = '0; exp_dir[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 oe", pin_oe, 16'h0);
        check("R1 out", pin_out, 16'h0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), 1'b1, rd);
            check("R1 rmw read", {8'h0, rd}, 16'h0);
            rd_reg(2'(a), 1'b0, rd);
            check("R1 pin read", {8'h0, rd}, 16'h0);
        end

        // R2, R5 exhaustive output register sweep
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr_reg(2'(2*p), 8'(v));
                exp_lat[p] = 8'(v);
                check("R2 pin_out", pin_out, {exp_lat[1], exp_lat[0]});
                rd_reg(2'(2*p), 1'b1, rd);
                check("R5 rmw read", {8'h0, rd}, {8'h0, 8'(v)});
            end
        end

        // R3, R6 exhaustive direction sweep
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr_reg(2'(2*p + 1), 8'(v ^ 8'h5a));
                exp_dir[p] = 8'(v ^ 8'h5a);
                check("R3 pin_oe", pin_oe, {exp_dir[1], exp_dir[0]});
                rd_reg(2'(2*p + 1), 1'b0, rd);
                check("R6 dir read", {8'h0, rd}, 16'h0);
            end
        end

        // R4 pin read with two-edge latency
        prev = 8'h00;
        pin_in = 16'h0;
        two_edges();
        for (int v = 1; v < 256; v++) begin
            @(negedge clk);
            pin_in = {8'(~v), 8'(v)};
            @(posedge clk);
            @(negedge clk);
            rd_reg(2'd0, 1'b0, rd);
            check("R4 one edge", {8'h0, rd}, {8'h0, prev});
            @(posedge clk);
            @(negedge clk);
            rd_reg(2'd0, 1'b0, rd);
            check("R4 port0", {8'h0, rd}, {8'h0, 8'(v)});
            rd_reg(2'd2, 1'b0, rd);
            check("R4 port1", {8'h0, rd}, {8'h0, 8'(~v)});
            prev = 8'(v);
        end

        // R7 float control
        wr_reg(2'd1, 8'hff); exp_dir[0] = 8'hff;
        wr_reg(2'd3, 8'hff); exp_dir[1] = 8'hff;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            stop_mode = c[1]; pin_float = c[0];
            #1;
            check("R7 oe", pin_oe, (c == 3) ? 16'h0 : 16'hffff);
        end
        @(negedge clk);
        stop_mode = 1'b0; pin_float = 1'b0;

        // R8 input gating in stop mode
        pin_in = 16'hffff;
        two_edges();
        rd_reg(2'd0, 1'b0, rd);
        check("R8 pins before stop", {8'h0, rd}, 16'h00ff);
        stop_mode = 1'b1;
        two_edges();
        rd_reg(2'd0, 1'b0, rd);
        check("R8 gated port0", {8'h0, rd}, 16'h0);
        rd_reg(2'd2, 1'b0, rd);
        check("R8 gated port1", {8'h0, rd}, 16'h0);
        rd_reg(2'd2, 1'b1, rd);
        check("R8 rmw in stop", {8'h0, rd}, {8'h0, exp_lat[1]});
        stop_mode = 1'b0;
        two_edges();
        rd_reg(2'd2, 1'b0, rd);
        check("R8 after stop", {8'h0, rd}, 16'h00ff);

        // R9 external bus mode
        wr_reg(2'd0, 8'h3c); exp_lat[0] = 8'h3c;
        wr_reg(2'd1, 8'h0f); exp_dir[0] = 8'h0f;
        ext_bus_mode = 1'b1;
        #1;
        check("R9 oe released", pin_oe, 16'h0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), 1'b1, rd);
            check("R9 read zero", {8'h0, rd}, 16'h0);
        end
        for (int a = 0; a < 4; a++) wr_reg(2'(a), 8'ha5);
        ext_bus_mode = 1'b0;
        #1;
        check("R9 latches kept", pin_out, {exp_lat[1], exp_lat[0]});
        check("R9 dir kept", pin_oe, {exp_dir[1], exp_dir[0]});

        // R10 read-modify-write with pin held low
        wr_reg(2'd0, 8'h01); exp_lat[0] = 8'h01;
        wr_reg(2'd1, 8'h01); exp_dir[0] = 8'h01;
        pin_in = 16'h0;
        two_edges();
        rd_reg(2'd0, 1'b0, rd);
        check("R10 pin read low", {8'h0, rd}, 16'h0);
        rd_reg(2'd0, 1'b1, rd);
        check("R10 rmw sees latch", {8'h0, rd}, 16'h0001);
        wr_reg(2'd0, rd | 8'h08);
        check("R10 latch survives", {8'h0, pin_out[7:0]}, 16'h0009);
        check("R10 still driving", {8'h0, pin_oe[7:0]}, 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule